// File: doc/BRIEF.md
# Programmable Conversion Strobe Generator

This block drives the conversion strobe for two independent banks of six converters. Each bank has its own 12-bit period word, so the two banks can sample at different rates. The period is counted on a 250 MHz capture clock, which makes one unit of the period word 4 ns. The strobe is high for the first four clock cycles of every period and low for the rest. A period word of 25 therefore gives a 100 ns period, or 10 MHz.

Each bank runs only while its gate bit is set. That bit is the enable of the first converter in the bank. The timing reference can come from the on-board oscillator or from an external clock recovered by a PLL. When the external reference is selected and the PLL has not locked, both banks are held idle. The block reports which banks are currently running.

Period words outside the legal range are pulled to the nearest limit. A new period word takes effect only when the current period ends. The strobe and status outputs come straight from flops.

Top module: `conv_strobe_gen`

## Requirements
- R1: After reset both strobe outputs and both `grp_active` bits are 0.
- R2: While a bank runs with a legal period word P, its strobe repeats every P clock cycles. It is high for exactly the first 4 cycles of each period and low for the remaining P-4 cycles.
- R3: A period word below 25 behaves exactly like 25.
- R4: A period word above 2500 behaves exactly like 2500.
- R5: The strobe rises and `grp_active` rises on the first clock edge at which the bank is allowed to run. A bank is allowed to run when its gate bit is 1 and the reference is usable.
- R6: On the first edge at which a bank is no longer allowed to run, its strobe and `grp_active` go to 0. A later restart begins a fresh period.
- R7: A change of the period word while a bank runs takes effect only at the end of the current period. The period in progress keeps its length.
- R8: The two banks are independent. Bank 0 uses `period_cfg[11:0]` and `grp_enable[0]`, and bank 1 uses `period_cfg[23:12]` and `grp_enable[1]`. Neither bank's timing is affected by the other bank's inputs.
- R9: When `clk_src_ext` is 1 and `pll_locked` is 0, no bank runs. When `clk_src_ext` is 0, `pll_locked` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 MHz capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cfg | input | 24 | Period words in 4 ns units; bits 11:0 are bank 0, bits 23:12 are bank 1 |
| grp_enable | input | 2 | Per-bank gate (enable of the first converter of each bank) |
| clk_src_ext | input | 1 | 0 selects the on-board oscillator, 1 selects the external clock |
| pll_locked | input | 1 | Lock indication of the external-clock PLL |
| strobe | output | 2 | Registered conversion strobe per bank |
| grp_active | output | 2 | Per-bank running status |

## Verification
Every result of this block appears one clock edge after the input that causes it. A bank that becomes allowed to run shows a high strobe and a set status after the very next rising edge. After that, the strobe level k edges later is known from k modulo the clamped period. Inputs are driven on the falling edge and outputs are sampled on the following falling edges. Sample k is therefore compared against (k mod P) < 4, and a disable or a lock loss is checked at the first falling edge after it.

// File: rtl/csg_pkg.sv
package csg_pkg;
   // Capture clock step in picoseconds (informational scale of one period unit)
   localparam int unsigned STEP_PS = 4000;

   // Reference choice encoded in the source-select input
   typedef enum logic {
      REF_ONBOARD  = 1'b0,
      REF_EXTERNAL = 1'b1
   } ref_src_e;

   // Per-bank timer phase
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PULSE = 2'd1,
      PH_QUIET = 2'd2
   } timer_phase_e;
endpackage

// File: rtl/csg_period_clamp.sv
module csg_period_clamp #(
   parameter int unsigned IN_W  = 12,
   parameter int unsigned OUT_W = 12,
   parameter int unsigned LO    = 25,
   parameter int unsigned HI    = 2500
) (
   input  logic [IN_W-1:0]  raw_word,
   output logic [OUT_W-1:0] lim_word
);
   localparam logic [IN_W-1:0]  LO_IN  = IN_W'(LO);
   localparam logic [IN_W-1:0]  HI_IN  = IN_W'(HI);
   localparam logic [OUT_W-1:0] LO_OUT = OUT_W'(LO);
   localparam logic [OUT_W-1:0] HI_OUT = OUT_W'(HI);

   initial begin
      assert (LO <= HI) else $error("clamp: lower bound above upper bound");
      assert (HI < (1 << IN_W)) else $error("clamp: upper bound does not fit the input word");
      assert (HI < (1 << OUT_W)) else $error("clamp: upper bound does not fit the output word");
   end

   logic under, over;

   always_comb begin
      under = (raw_word < LO_IN);
      over  = (raw_word > HI_IN);
      if (under)
         lim_word = LO_OUT;
      else if (over)
         lim_word = HI_OUT;
      else
         lim_word = OUT_W'(raw_word);
   end
endmodule

// File: rtl/csg_ref_qualify.sv
module csg_ref_qualify #(
   parameter int unsigned NUM_GROUPS   = 2,
   parameter bit          REQUIRE_LOCK = 1'b1
) (
   input  logic [NUM_GROUPS-1:0] gate_in,
   input  logic                  src_ext,
   input  logic                  lock_in,
   output logic [NUM_GROUPS-1:0] run_req
);
   import csg_pkg::*;

   initial begin
      assert (NUM_GROUPS >= 1) else $error("qualify: need at least one bank");
   end

   logic ref_ok;

   generate
      if (REQUIRE_LOCK) begin : g_lock_gate
         always_comb begin
            if (ref_src_e'(src_ext) == REF_EXTERNAL)
               ref_ok = lock_in;
            else
               ref_ok = 1'b1;
         end
      end else begin : g_no_lock_gate
         logic unused_lock;
         always_comb begin
            unused_lock = src_ext ^ lock_in;
            ref_ok      = 1'b1;
         end
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
         always_comb run_req[g] = gate_in[g] & ref_ok;
      end
   endgenerate
endmodule

// File: rtl/csg_group_timer.sv
module csg_group_timer #(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned MIN_PERIOD  = 25,
   parameter int unsigned MAX_PERIOD  = 2500,
   parameter int unsigned HIGH_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [CNT_W-1:0] period_lim,
   output logic             strobe_o,
   output logic             active_o
);
   import csg_pkg::*;

   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);
   localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_CYCLES);
   localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_PERIOD);
   localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(MAX_PERIOD);

   initial begin
      assert (HIGH_CYCLES >= 1) else $error("timer: pulse must last at least one cycle");
      assert (MIN_PERIOD > HIGH_CYCLES) else $error("timer: shortest period must exceed the pulse");
      assert (MAX_PERIOD < (1 << CNT_W)) else $error("timer: counter too narrow");
   end

   timer_phase_e phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             at_end;

   always_comb begin
      cnt_inc = cnt_q + ONE_V;
      at_end  = (cnt_q == (per_q - ONE_V));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         per_q   <= MIN_V;
      end else if (!run_req) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         per_q   <= period_lim;
      end else if (phase_q == PH_IDLE || at_end) begin
         phase_q <= PH_PULSE;
         cnt_q   <= '0;
         per_q   <= period_lim;
      end else begin
         cnt_q   <= cnt_inc;
         phase_q <= (cnt_inc < HIGH_V) ? PH_PULSE : PH_QUIET;
      end
   end

   // Strobe and status come straight out of dedicated flops
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_o <= 1'b0;
         active_o <= 1'b0;
      end else if (!run_req) begin
         strobe_o <= 1'b0;
         active_o <= 1'b0;
      end else if (phase_q == PH_IDLE || at_end) begin
         strobe_o <= 1'b1;
         active_o <= 1'b1;
      end else begin
         strobe_o <= (cnt_inc < HIGH_V);
         active_o <= 1'b1;
      end
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (cnt_q < per_q));

   // R2
   pulse_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> (cnt_q < HIGH_V));

   // R2
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && cnt_q == '0) |-> strobe_o);

   // R3 R4
   period_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |-> (per_q >= MIN_V && per_q <= MAX_V));

   // R5
   start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_req && !active_o) |=> (strobe_o && active_o));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_req |=> (!strobe_o && !active_o && cnt_q == '0));

   // R7
   period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && run_req && !at_end) |=> $stable(per_q));
endmodule

// File: rtl/conv_strobe_gen.sv
module conv_strobe_gen #(
   parameter int unsigned NUM_GROUPS   = 2,
   parameter int unsigned PERIOD_W     = 12,
   parameter int unsigned MIN_PERIOD   = 25,
   parameter int unsigned MAX_PERIOD   = 2500,
   parameter int unsigned HIGH_CYCLES  = 4,
   parameter bit          REQUIRE_LOCK = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_GROUPS*PERIOD_W-1:0] period_cfg,
   input  logic [NUM_GROUPS-1:0]          grp_enable,
   input  logic                           clk_src_ext,
   input  logic                           pll_locked,
   output logic [NUM_GROUPS-1:0]          strobe,
   output logic [NUM_GROUPS-1:0]          grp_active
);
   localparam int unsigned CNT_W = $clog2(MAX_PERIOD + 1);

   initial begin
      assert (NUM_GROUPS >= 1) else $error("top: need at least one bank");
      assert (MAX_PERIOD < (1 << PERIOD_W)) else $error("top: period word too narrow");
   end

   logic [NUM_GROUPS-1:0] run_req;

   csg_ref_qualify #(
      .NUM_GROUPS   (NUM_GROUPS),
      .REQUIRE_LOCK (REQUIRE_LOCK)
   ) u_qualify (
      .gate_in (grp_enable),
      .src_ext (clk_src_ext),
      .lock_in (pll_locked),
      .run_req (run_req)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
         logic [CNT_W-1:0] lim;

         csg_period_clamp #(
            .IN_W  (PERIOD_W),
            .OUT_W (CNT_W),
            .LO    (MIN_PERIOD),
            .HI    (MAX_PERIOD)
         ) u_clamp (
            .raw_word (period_cfg[g*PERIOD_W +: PERIOD_W]),
            .lim_word (lim)
         );

         csg_group_timer #(
            .CNT_W       (CNT_W),
            .MIN_PERIOD  (MIN_PERIOD),
            .MAX_PERIOD  (MAX_PERIOD),
            .HIGH_CYCLES (HIGH_CYCLES)
         ) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_req    (run_req[g]),
            .period_lim (lim),
            .strobe_o   (strobe[g]),
            .active_o   (grp_active[g])
         );
      end
   endgenerate

   // R9
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (REQUIRE_LOCK && clk_src_ext && !pll_locked) |=> (grp_active == '0 && strobe == '0));

   // R8
   gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_active & ~$past(grp_enable)) == '0);
endmodule

// File: tb/conv_strobe_gen_test.sv
`timescale 1ns/1ps
module conv_strobe_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] period_cfg = '0;
   logic [1:0]  grp_enable = '0;
   logic        clk_src_ext = 1'b0;
   logic        pll_locked = 1'b0;
   logic [1:0]  strobe;
   logic [1:0]  grp_active;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   conv_strobe_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_cfg  (period_cfg),
      .grp_enable  (grp_enable),
      .clk_src_ext (clk_src_ext),
      .pll_locked  (pll_locked),
      .strobe      (strobe),
      .grp_active  (grp_active)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int clampv(input int v);
      if (v < 25) return 25;
      if (v > 2500) return 2500;
      return v;
   endfunction

   // Runs bank g with word val and compares every cycle against (k mod P) < 4
   task automatic run_single(input int g, input int val, input string req);
      int p = clampv(val);
      int first_k = -1;
      int act = 0;
      int exp = 0;
      @(negedge clk);
      period_cfg[g*12 +: 12] = val[11:0];
      grp_enable = '0;
      grp_enable[g] = 1'b1;
      for (int k = 0; k < 2*p + 6; k++) begin
         @(negedge clk);
         if (first_k < 0 && (strobe[g] !== ((k % p) < 4) || strobe[1-g] !== 1'b0
                             || grp_active[g] !== 1'b1)) begin
            first_k = k;
            act = {strobe[1-g], grp_active[g], strobe[g]};
            exp = {1'b0, 1'b1, ((k % p) < 4)};
         end
      end
      check(first_k < 0, req, $sformatf("bank%0d word %0d pattern (first bad cycle %0d)",
            g, val, first_k), act, exp);
      grp_enable = '0;
      @(negedge clk);
      check(strobe == 2'b00 && grp_active == 2'b00, "R6", "outputs after disable",
            {strobe, grp_active}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int errs;
      repeat (3) @(negedge clk);
      // R1
      check(strobe == 2'b00 && grp_active == 2'b00, "R1", "outputs in reset",
            {strobe, grp_active}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(strobe == 2'b00 && grp_active == 2'b00, "R1", "outputs after reset",
            {strobe, grp_active}, 0);

      // R2 legal words
      run_single(0, 25, "R2");
      run_single(0, 26, "R2");
      run_single(1, 30, "R2");
      run_single(0, 100, "R2");
      run_single(1, 2500, "R2");
      // R3 low words
      run_single(0, 0, "R3");
      run_single(1, 10, "R3");
      run_single(0, 24, "R3");
      // R4 high words
      run_single(1, 2501, "R4");
      run_single(0, 4095, "R4");

      // R5 first edge after enable
      @(negedge clk);
      period_cfg[11:0] = 12'd40;
      grp_enable = 2'b01;
      @(negedge clk);
      check(strobe[0] === 1'b1 && grp_active[0] === 1'b1, "R5", "first strobe on first edge",
            {grp_active[0], strobe[0]}, 3);
      // R6 disable mid-period then restart gives a fresh period
      repeat (9) @(negedge clk);
      grp_enable = 2'b00;
      @(negedge clk);
      check(strobe == 2'b00 && grp_active == 2'b00, "R6", "mid-period disable",
            {strobe, grp_active}, 0);
      grp_enable = 2'b01;
      errs = 0;
      for (int k = 0; k < 45; k++) begin
         @(negedge clk);
         if (strobe[0] !== ((k % 40) < 4)) errs++;
      end
      check(errs == 0, "R6", "restart pattern errors", errs, 0);
      grp_enable = 2'b00;
      @(negedge clk);

      // R7 period change mid-period: 40 completes, then 60
      period_cfg[11:0] = 12'd40;
      grp_enable = 2'b01;
      errs = 0;
      for (int k = 0; k < 110; k++) begin
         @(negedge clk);
         if (strobe[0] !== ((k < 4) || (k >= 40 && k < 44) || (k >= 100 && k < 104))) errs++;
         if (k == 10) period_cfg[11:0] = 12'd60;
      end
      check(errs == 0, "R7", "deferred period change errors", errs, 0);
      grp_enable = 2'b00;
      @(negedge clk);

      // R8 both banks concurrently at different rates
      period_cfg = {12'd31, 12'd25};
      grp_enable = 2'b11;
      errs = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (strobe[0] !== ((k % 25) < 4)) errs++;
         if (strobe[1] !== ((k % 31) < 4)) errs++;
         if (k == 50) period_cfg[23:12] = 12'd31;
      end
      check(errs == 0, "R8", "concurrent bank errors", errs, 0);
      // R8 disabling bank 1 leaves bank 0 phase intact
      grp_enable = 2'b01;
      errs = 0;
      for (int k = 200; k < 260; k++) begin
         @(negedge clk);
         if (strobe[0] !== ((k % 25) < 4) || strobe[1] !== 1'b0) errs++;
      end
      check(errs == 0, "R8", "bank0 after bank1 off errors", errs, 0);
      grp_enable = 2'b00;
      @(negedge clk);

      // R9 external reference without lock holds banks idle
      clk_src_ext = 1'b1;
      pll_locked = 1'b0;
      grp_enable = 2'b11;
      errs = 0;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         if (strobe != 2'b00 || grp_active != 2'b00) errs++;
      end
      check(errs == 0, "R9", "activity while unlocked", errs, 0);
      pll_locked = 1'b1;
      @(negedge clk);
      check(strobe == 2'b11 && grp_active == 2'b11, "R9", "start on lock",
            {strobe, grp_active}, 15);
      pll_locked = 1'b0;
      @(negedge clk);
      check(strobe == 2'b00 && grp_active == 2'b00, "R9", "stop on lock loss",
            {strobe, grp_active}, 0);
      // R9 on-board reference ignores lock
      clk_src_ext = 1'b0;
      @(negedge clk);
      check(strobe == 2'b11 && grp_active == 2'b11, "R9", "onboard ignores lock",
            {strobe, grp_active}, 15);
      grp_enable = 2'b00;
      @(negedge clk);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule